// File: doc/BRIEF.md
# External Memory Bus Strobe Generator

This block produces the timing strobes for a multiplexed external memory bus. A free-running counter splits the oscillator clock into machine cycles of twelve clocks. From that counter it drives the address-latch pulse, the active-low program read strobe and the source select for the high address port. A sequencer tells the block what the next machine cycle will do by presenting four attribute inputs during the last clock of the current cycle: code fetch from external memory, external data access, wide data address, and table read. The block latches them at that boundary and holds them for the whole of the following cycle.

A one-bit control register, written through a small register port, can release the latch output so that it rests high. While the bit is set, a latch pulse is still driven in cycles that carry a table read or an external data access. External code fetch overrides the bit. A reset-pin qualifier synchronizes the external reset pin and reports a core reset only after the pin has stayed high for two full machine cycles. That qualified reset also clears the control bit.

Top module: `ext_bus_strobe`

## Requirements
- R1: After `rst_ni` is released, the clock edges are numbered k = 1, 2, ... and slot s = k mod 12 (with s in 0..11) describes the state after edge k. `cyc_last_o` is 1 exactly in slot 11. In a cycle with no data access and the latch output driven, `ale_o` is 1 for one clock in slots 1 and 7 and is 0 otherwise.
- R2: In a cycle flagged as an external data access, the slot-1 latch pulse is skipped and the slot-7 pulse remains, giving exactly one pulse.
- R3: A register write with `reg_we_i`=1 and `reg_addr_i`=8'h8E loads `reg_wdata_i[0]` into the disable bit. Writes to any other address have no effect. While the bit is 1 in a cycle with no fetch, data or table attribute, `ale_drive_o` is 0 and `ale_o` is 1 for the whole cycle.
- R4: While the disable bit is 1, a cycle flagged as table read or data access drives the latch output (`ale_drive_o`=1) and pulses it as in R1 and R2.
- R5: The disable bit has no effect in a cycle flagged as an external code fetch.
- R6: In a fetch cycle without a data access, `psen_no` is 0 in slots 0 to 3 and 6 to 9, giving two assertions. In every other cycle `psen_no` stays 1, so a data access removes both assertions.
- R7: `p2_addr_sel_o` (1 = high address byte, 0 = port register) equals the wide-address flag in a data-access cycle. In any other cycle it equals the fetch flag.
- R8: The attributes are sampled only at the edge that leaves slot 11, and they are held for the next twelve clocks. Changes at any other time have no effect.
- R9: `rst_pin_i` passes through a two-stage synchronizer. `core_rst_o` goes to 1 once the synchronized pin has been 1 for 24 consecutive clocks, and it returns to 0 one clock after the synchronized pin goes low.
- R10: While `core_rst_o` is 1, the disable bit is cleared, and this takes priority over a register write.
- R11: While `rst_ni` is 0, the outputs are `ale_o`=0, `ale_drive_o`=1, `psen_no`=1, `p2_addr_sel_o`=0, `cyc_last_o`=0 and `core_rst_o`=0, and the disable bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rst_pin_i | input | 1 | External reset pin, asynchronous, active high |
| ext_fetch_i | input | 1 | Next cycle fetches code from external memory |
| xdata_i | input | 1 | Next cycle is an external data access |
| xdata_wide_i | input | 1 | Data access uses a 16-bit address |
| tbl_read_i | input | 1 | Next cycle belongs to a code table read |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register write address |
| reg_wdata_i | input | 8 | Register write data |
| ale_o | output | 1 | Address-latch pulse, resting level 1 when released |
| ale_drive_o | output | 1 | 1 while the latch output is actively driven |
| psen_no | output | 1 | Program read strobe, active low |
| p2_addr_sel_o | output | 1 | High port source: 1 address byte, 0 port register |
| cyc_last_o | output | 1 | Last clock of the machine cycle |
| core_rst_o | output | 1 | Qualified core reset |

## Verification
Three pairs of functions can act on the same clock. A register write to the disable bit can coincide with an active qualified reset: the bench holds the reset pin high and issues a write to set the bit, and it expects the bit to stay clear, which shows as `ale_drive_o` remaining 1. A fetch attribute and a data attribute can fall in the same cycle: the bench presents both together and expects no read strobes, a single slot-7 latch pulse, and a port select that follows the wide flag. The disable bit set together with a fetch cycle also occurs: the bench expects the pulses to be driven regardless. Each of these outcomes is judged clock by clock against a behavioural model.

// File: rtl/ext_bus_strobe_pkg.sv
package ext_bus_strobe_pkg;

  typedef struct packed {
    logic fetch;
    logic xdata;
    logic wide;
    logic tbl;
  } cyc_attr_t;

  localparam cyc_attr_t ATTR_IDLE = '{fetch: 1'b0, xdata: 1'b0, wide: 1'b0, tbl: 1'b0};

  typedef struct packed {
    logic ale;
    logic ale_drive;
    logic psen_n;
    logic p2_sel;
    logic last;
  } strobe_out_t;

endpackage

// File: rtl/ebs_cycle_timer.sv
module ebs_cycle_timer #(
  parameter int CYC_CLKS = 12,
  localparam int CW = $clog2(CYC_CLKS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [CW-1:0] slot_q_o,
  output logic [CW-1:0] slot_d_o,
  output logic          wrap_o
);

  localparam logic [CW-1:0] LAST = CW'(CYC_CLKS - 1);

  logic [CW-1:0] slot_q;

  assign wrap_o   = (slot_q == LAST);
  assign slot_d_o = wrap_o ? '0 : slot_q + 1'b1;
  assign slot_q_o = slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slot_q <= '0;
    else         slot_q <= slot_d_o;
  end

endmodule

// File: rtl/ebs_reset_qual.sv
module ebs_reset_qual #(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CLKS   = 24,
  localparam int HW = $clog2(HOLD_CLKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic core_rst_o
);

  localparam logic [HW-1:0] HOLD = HW'(HOLD_CLKS);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [HW-1:0]          hold_q;
  logic                   pin_s;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[0] <= 1'b0;
          else         sync_q[0] <= pin_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[i] <= 1'b0;
          else         sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  assign pin_s = sync_q[SYNC_STAGES-1];

  // saturating run-length of the synchronized pin
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            hold_q <= '0;
    else if (!pin_s)        hold_q <= '0;
    else if (hold_q != HOLD) hold_q <= hold_q + 1'b1;
  end

  assign core_rst_o = (hold_q == HOLD);

endmodule

// File: rtl/ebs_ctrl_reg.sv
module ebs_ctrl_reg #(
  parameter int              ADDR_W    = 8,
  parameter int              DATA_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h8E,
  parameter int              DIS_BIT   = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              core_rst_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              dis_q_o,
  output logic              dis_d_o
);

  logic dis_q;
  logic hit;

  assign hit = we_i && (addr_i == CTRL_ADDR);

  always_comb begin
    dis_d_o = dis_q;
    if (core_rst_i) dis_d_o = 1'b0;
    else if (hit)   dis_d_o = wdata_i[DIS_BIT];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dis_q <= 1'b0;
    else         dis_q <= dis_d_o;
  end

  assign dis_q_o = dis_q;

endmodule

// File: rtl/ebs_strobe_dec.sv
module ebs_strobe_dec
  import ext_bus_strobe_pkg::*;
#(
  parameter int CYC_CLKS   = 12,
  parameter int ALE_SLOT_A = 1,
  parameter int ALE_SLOT_B = 7,
  parameter int PSEN_A     = 0,
  parameter int PSEN_B     = 6,
  parameter int PSEN_LEN   = 4,
  localparam int CW = $clog2(CYC_CLKS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] slot_d_i,
  input  cyc_attr_t     attr_d_i,
  input  logic          dis_d_i,
  output strobe_out_t   out_o
);

  localparam logic [CW-1:0] SA   = CW'(ALE_SLOT_A);
  localparam logic [CW-1:0] SB   = CW'(ALE_SLOT_B);
  localparam logic [CW-1:0] PA0  = CW'(PSEN_A);
  localparam logic [CW-1:0] PA1  = CW'(PSEN_A + PSEN_LEN - 1);
  localparam logic [CW-1:0] PB0  = CW'(PSEN_B);
  localparam logic [CW-1:0] PB1  = CW'(PSEN_B + PSEN_LEN - 1);
  localparam logic [CW-1:0] LAST = CW'(CYC_CLKS - 1);

  strobe_out_t nxt, out_q;
  logic        drive, pulse, psen_win;

  // decode from next-state values so the flops hold the decode of the current state
  always_comb begin
    drive    = !dis_d_i || attr_d_i.fetch || attr_d_i.xdata || attr_d_i.tbl;
    pulse    = ((slot_d_i == SA) && !attr_d_i.xdata) || (slot_d_i == SB);
    psen_win = ((slot_d_i >= PA0) && (slot_d_i <= PA1)) ||
               ((slot_d_i >= PB0) && (slot_d_i <= PB1));
    nxt.ale       = drive ? pulse : 1'b1;
    nxt.ale_drive = drive;
    nxt.psen_n    = !(attr_d_i.fetch && !attr_d_i.xdata && psen_win);
    nxt.p2_sel    = attr_d_i.xdata ? attr_d_i.wide : attr_d_i.fetch;
    nxt.last      = (slot_d_i == LAST);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= '{ale: 1'b0, ale_drive: 1'b1, psen_n: 1'b1, p2_sel: 1'b0, last: 1'b0};
    else         out_q <= nxt;
  end

  assign out_o = out_q;

endmodule

// File: rtl/ext_bus_strobe.sv
module ext_bus_strobe
  import ext_bus_strobe_pkg::*;
#(
  parameter int              CYC_CLKS    = 12,
  parameter int              RST_CYCLES  = 2,
  parameter int              SYNC_STAGES = 2,
  parameter int              ADDR_W      = 8,
  parameter int              DATA_W      = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h8E
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rst_pin_i,
  input  logic              ext_fetch_i,
  input  logic              xdata_i,
  input  logic              xdata_wide_i,
  input  logic              tbl_read_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic              ale_o,
  output logic              ale_drive_o,
  output logic              psen_no,
  output logic              p2_addr_sel_o,
  output logic              cyc_last_o,
  output logic              core_rst_o
);

  localparam int CW       = $clog2(CYC_CLKS);
  localparam int STATE_CK = CYC_CLKS / 6;
  localparam int HOLD_CLKS = RST_CYCLES * CYC_CLKS;

  logic [CW-1:0] slot_q, slot_d;
  logic          wrap;
  logic          ale_dis, ale_dis_d;
  cyc_attr_t     attr_q, attr_d, attr_in;
  strobe_out_t   so;

  ebs_cycle_timer #(.CYC_CLKS(CYC_CLKS)) u_timer (
    .clk_i, .rst_ni, .slot_q_o(slot_q), .slot_d_o(slot_d), .wrap_o(wrap)
  );

  ebs_reset_qual #(.SYNC_STAGES(SYNC_STAGES), .HOLD_CLKS(HOLD_CLKS)) u_rq (
    .clk_i, .rst_ni, .pin_i(rst_pin_i), .core_rst_o
  );

  ebs_ctrl_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR), .DIS_BIT(0)) u_ctrl (
    .clk_i, .rst_ni, .core_rst_i(core_rst_o), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .dis_q_o(ale_dis), .dis_d_o(ale_dis_d)
  );

  assign attr_in = '{fetch: ext_fetch_i, xdata: xdata_i, wide: xdata_wide_i, tbl: tbl_read_i};
  assign attr_d  = wrap ? attr_in : attr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) attr_q <= ATTR_IDLE;
    else         attr_q <= attr_d;
  end

  // latch in the second clock of states 1 and 4; read strobe over states 1-2 and 4-5
  ebs_strobe_dec #(
    .CYC_CLKS  (CYC_CLKS),
    .ALE_SLOT_A(STATE_CK - 1),
    .ALE_SLOT_B(3 * STATE_CK + STATE_CK - 1),
    .PSEN_A    (0),
    .PSEN_B    (3 * STATE_CK),
    .PSEN_LEN  (2 * STATE_CK)
  ) u_dec (
    .clk_i, .rst_ni, .slot_d_i(slot_d), .attr_d_i(attr_d), .dis_d_i(ale_dis_d), .out_o(so)
  );

  assign ale_o         = so.ale;
  assign ale_drive_o   = so.ale_drive;
  assign psen_no       = so.psen_n;
  assign p2_addr_sel_o = so.p2_sel;
  assign cyc_last_o    = so.last;

endmodule

// File: rtl/ext_bus_strobe_chk.sv
module ext_bus_strobe_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ale_o,
  input logic ale_drive_o,
  input logic psen_no,
  input logic p2_addr_sel_o,
  input logic cyc_last_o,
  input logic core_rst_o,
  input logic reg_we_i,
  input logic ale_dis
);

  // R1
  ale_one_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ale_o && ale_drive_o) |=> !(ale_o && ale_drive_o));

  // R1
  last_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_last_o |=> !cyc_last_o);

  // R5
  psen_needs_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !psen_no |-> ale_drive_o);

  // R8
  p2_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_last_o |=> $stable(p2_addr_sel_o));

  // R10
  rst_clears_dis_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rst_o |=> !ale_dis);

  // R3
  dis_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reg_we_i && !core_rst_o) |=> $stable(ale_dis));

endmodule

bind ext_bus_strobe ext_bus_strobe_chk u_chk (
  .clk_i, .rst_ni, .ale_o, .ale_drive_o, .psen_no, .p2_addr_sel_o,
  .cyc_last_o, .core_rst_o, .reg_we_i, .ale_dis
);

// File: tb/sim_ext_bus_strobe.sv
`timescale 1ns/1ps
module sim_ext_bus_strobe;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b0, fetch = 1'b0, xd = 1'b0, wide = 1'b0, tbl = 1'b0;
  logic we = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic ale, drv, psen_n, p2, last, crst;

  always #2 clk = ~clk;

  ext_bus_strobe u0 (
    .clk_i(clk), .rst_ni(rst_n), .rst_pin_i(pin), .ext_fetch_i(fetch), .xdata_i(xd),
    .xdata_wide_i(wide), .tbl_read_i(tbl), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .ale_o(ale), .ale_drive_o(drv), .psen_no(psen_n),
    .p2_addr_sel_o(p2), .cyc_last_o(last), .core_rst_o(crst)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // behavioural reference
  int  m_slot = 0, m_hold = 0;
  bit  m_f = 0, m_x = 0, m_w = 0, m_t = 0, m_dis = 0, m_rst = 0;
  bit  m_sync[$] = '{0, 0};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_slot = 0; m_hold = 0; m_f = 0; m_x = 0; m_w = 0; m_t = 0;
      m_dis = 0; m_rst = 0; m_sync = '{0, 0};
    end else begin
      if (m_rst) m_dis = 0;
      else if (we && addr == 8'h8E) m_dis = wdata[0];
      if (m_slot == 11) begin m_f = fetch; m_x = xd; m_w = wide; m_t = tbl; end
      m_slot = (m_slot + 1) % 12;
      if (m_sync[1]) m_hold = (m_hold < 24) ? m_hold + 1 : 24; else m_hold = 0;
      m_sync.pop_back();
      m_sync.push_front(pin);
      m_rst = (m_hold == 24);
    end
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  // per-clock comparison and pulse counters
  int ale_cnt = 0, psen_cnt = 0;
  logic ale_p = 0, psen_p = 1;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit drive_e, ale_e, psen_e;
      drive_e = !m_dis || m_f || m_x || m_t;
      ale_e   = drive_e ? (((m_slot == 1) && !m_x) || (m_slot == 7)) : 1'b1;
      psen_e  = !(m_f && !m_x && ((m_slot <= 3) || (m_slot >= 6 && m_slot <= 9)));
      check("R1 ale_o", ale, ale_e);
      check("R3 ale_drive_o", drv, drive_e);
      check("R6 psen_no", psen_n, psen_e);
      check("R7 p2_addr_sel_o", p2, m_x ? m_w : m_f);
      check("R1 cyc_last_o", last, m_slot == 11);
      check("R9 core_rst_o", crst, m_rst);
      if (ale && drv && !ale_p) ale_cnt++;
      if (!psen_n && psen_p) psen_cnt++;
      ale_p = ale && drv;
      psen_p = psen_n;
    end
  end

  task automatic to_boundary();
    do @(negedge clk); while (!last);
  endtask

  // present attributes at a boundary, run one whole cycle, return at the next boundary
  task automatic run_cyc(bit f, bit x, bit w, bit t, output int na, output int np);
    fetch = f; xd = x; wide = w; tbl = t;
    ale_cnt = 0; psen_cnt = 0;
    @(negedge clk);
    fetch = 0; xd = 0; wide = 0; tbl = 0;  // R8: later changes must not matter
    repeat (11) @(negedge clk);
    na = ale_cnt; np = psen_cnt;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int na, np;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 ale_o", ale, 0);
    check("R11 ale_drive_o", drv, 1);
    check("R11 psen_no", psen_n, 1);
    check("R11 p2_addr_sel_o", p2, 0);
    check("R11 cyc_last_o", last, 0);
    check("R11 core_rst_o", crst, 0);
    rst_n = 1;
    to_boundary();
    run_cyc(0, 0, 0, 0, na, np); check("R1 pulses idle", na, 2); check("R6 idle psen", np, 0);
    run_cyc(1, 0, 0, 0, na, np); check("R1 pulses fetch", na, 2); check("R6 fetch psen", np, 2);
    run_cyc(1, 1, 1, 0, na, np); check("R2 pulses xdata", na, 1); check("R6 xdata psen", np, 0);
    run_cyc(0, 1, 0, 0, na, np); check("R2 pulses narrow", na, 1);
    // R8: attribute raised mid-cycle is ignored
    @(negedge clk); fetch = 1; repeat (5) @(negedge clk); fetch = 0;
    check("R8 p2 mid", p2, 0);
    to_boundary();
    wr(8'h8F, 8'h01); wr(8'h0E, 8'hFF);
    to_boundary();
    run_cyc(0, 0, 0, 0, na, np); check("R3 other addr ignored", na, 2);
    wr(8'h8E, 8'h01);
    to_boundary();
    run_cyc(0, 0, 0, 0, na, np); check("R3 released", na, 0); check("R3 drive", drv, 0);
    run_cyc(0, 0, 0, 1, na, np); check("R4 table read", na, 2);
    run_cyc(0, 1, 1, 0, na, np); check("R4 xdata", na, 1);
    run_cyc(1, 0, 0, 0, na, np); check("R5 fetch overrides", na, 2); check("R5 psen", np, 2);
    run_cyc(1, 1, 0, 0, na, np); check("R5 fetch+xdata", na, 1); check("R6 fetch+xdata psen", np, 0);
    // R9 short glitch
    @(negedge clk); pin = 1; repeat (20) @(negedge clk); pin = 0;
    repeat (6) @(negedge clk); check("R9 glitch", crst, 0);
    // R9/R10 long hold with a competing write
    pin = 1; repeat (30) @(negedge clk); check("R9 asserted", crst, 1);
    wr(8'h8E, 8'h01);
    pin = 0; repeat (4) @(negedge clk); check("R9 released", crst, 0);
    to_boundary();
    run_cyc(0, 0, 0, 0, na, np); check("R10 bit cleared", na, 2);
    repeat (5) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule